// File: doc/BRIEF.md
# Chunked Firmware DMA Loader

This block copies one firmware section from external memory into an engine's instruction or data memory by driving the register interface of a separate transfer engine. A caller supplies a descriptor and pulses `start`. The descriptor holds a base DMA address, a source offset, a destination offset, a byte length, the size of the source object, a target select and a secure flag. The loader validates the descriptor and programs the two base-address registers. It then walks the section in fixed 256-byte chunks. Each chunk takes three register writes, and the loader waits for the engine to report idle before it starts the next chunk.

The two targets treat the source offset differently. For an instruction-memory target the base address is used as given, and the source offset is added to every chunk's external offset. For a data-memory target the source offset is added into the base address, and the external offset starts at zero. When the loader finishes, it pulses `done` for one cycle and presents a result code. The code stays valid until the next accepted request.

Top module: `fw_chunk_loader`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low, and `busy` is high in the following cycle. The descriptor is captured at acceptance. A `start` while busy is ignored, and the ongoing sequence and its writes are unchanged.
- R2: The effective start address is the base for an instruction target, or the base plus the source offset for a data target. If its low 8 bits are not zero, the request ends with code 1 and no register write.
- R3: If the effective start address does not fit in 49 bits, the request ends with code 2 and no register write.
- R4: Let chunks = ceil(length/256). If chunks×256 + source offset does not fit in 32 bits, the request ends with code 3 and no register write.
- R5: If chunks×256 + source offset is greater than the object size, the request ends with code 4 and no register write. A value exactly equal to the object size is accepted.
- R6: When several checks fail, the reported code follows the order misaligned (1), range (2), overflow (3), beyond object (4).
- R7: A valid request first writes select 0 with bits 39:8 of the effective address. It then writes select 1 with bits 55:40 of the effective address, zero-extended to 32 bits.
- R8: Chunk i writes select 2 with destination offset + i×256. It then writes select 3 with first external offset + i×256. The first external offset is the source offset for an instruction target and zero for a data target.
- R9: Each chunk ends with a select 4 command word. Bit 0 is set for an instruction target, bit 1 carries the secure flag, bits 6:4 hold size code 6 (256 bytes), and all other bits are zero. Exactly ceil(length/256) commands are issued.
- R10: After a command, no register write occurs until `eng_idle` is seen high.
- R11: If `eng_idle` stays low for TIMEOUT_CYCLES cycles after a command, the request ends with code 5 and no further writes.
- R12: A valid request with zero length ends with code 0 and no register write.
- R13: Completion is a single-cycle `done` pulse. It comes two cycles after the accepting edge for a rejected or zero-length request. `err_code` holds the result until the next accepted start, and success is code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| desc_base | input | 64 | Base DMA address of the source object |
| desc_src_off | input | 32 | Source offset inside the object |
| desc_dst_off | input | 32 | Destination offset inside the engine memory |
| desc_len | input | 32 | Section length in bytes |
| desc_obj_size | input | 32 | Size of the source object in bytes |
| desc_to_imem | input | 1 | 1 = instruction memory target, 0 = data memory |
| desc_secure | input | 1 | Secure flag for the command word |
| eng_idle | input | 1 | Transfer engine idle status |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 3 | Register select: 0 base low, 1 base high, 2 memory offset, 3 external offset, 4 command |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| err_code | output | 3 | Result code |

## Verification
Rejected and zero-length requests must raise `done` exactly two edges after the accepting edge. The bench counts falling edges from the start pulse and requires `done` at the second. On a valid request, each register write follows the previous one on the next edge, except the first write of a new chunk, which waits for idle. The bench logs every write at the rising edge and compares the ordered log against a list built from the descriptor, so the cycle of each write does not affect the comparison. The bench checks the result code on the falling edge where `done` is seen. One cycle later it checks that `done` has dropped and that the code is held.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
    localparam int ADDR_W       = 64;
    localparam int OFF_W        = 32;
    localparam int DATA_W       = 32;
    localparam int CHUNK_SH     = 8;
    localparam int ADDR_LIMIT_W = 49;
    localparam int HI_SHIFT     = 40;
    localparam int HI_W         = 16;
    localparam int CNT_W        = OFF_W + 1 - CHUNK_SH;
    localparam int SEL_W        = 3;
    localparam logic [2:0] SIZE_CODE = 3'h6;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_ALIGN   = 3'd1,
        ERR_RANGE   = 3'd2,
        ERR_OVF     = 3'd3,
        ERR_BEYOND  = 3'd4,
        ERR_TIMEOUT = 3'd5
    } err_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_BASE_LO = 3'd0,
        SEL_BASE_HI = 3'd1,
        SEL_MEM_OFF = 3'd2,
        SEL_EXT_OFF = 3'd3,
        SEL_CMD     = 3'd4
    } sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [OFF_W-1:0]  src_off;
        logic [OFF_W-1:0]  dst_off;
        logic [OFF_W-1:0]  len;
        logic [OFF_W-1:0]  obj_size;
        logic              to_imem;
        logic              secure;
    } desc_t;

    typedef struct packed {
        err_e              err;
        logic [ADDR_W:0]   start_addr;
        logic [OFF_W-1:0]  ext_first;
        logic [CNT_W-1:0]  chunks;
    } plan_t;

    function automatic logic [DATA_W-1:0] make_cmd(logic imem, logic sec);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[0]   = imem;
        w[1]   = sec;
        w[6:4] = SIZE_CODE;
        return w;
    endfunction
endpackage

// File: rtl/fwl_validate.sv
module fwl_validate
    import fwl_pkg::*;
(
    input  desc_t desc,
    output plan_t plan
);
    localparam int LEN_W = OFF_W + 1;
    localparam int UB_W  = OFF_W + 2;

    logic [ADDR_W:0]   eff_addr;
    logic [LEN_W-1:0]  len_round;
    logic [CNT_W-1:0]  n_chunks;
    logic [LEN_W-1:0]  span;
    logic [UB_W-1:0]   upper;
    logic              bad_align, bad_range, bad_ovf, bad_beyond;

    always_comb begin
        eff_addr   = {1'b0, desc.base}
                   + (ADDR_W+1)'(desc.to_imem ? '0 : desc.src_off);
        len_round  = {1'b0, desc.len} + LEN_W'((1 << CHUNK_SH) - 1);
        n_chunks   = len_round[LEN_W-1:CHUNK_SH];
        span       = {n_chunks, {CHUNK_SH{1'b0}}};
        upper      = UB_W'(span) + UB_W'(desc.src_off);
        bad_align  = |eff_addr[CHUNK_SH-1:0];
        bad_range  = |eff_addr[ADDR_W:ADDR_LIMIT_W];
        bad_ovf    = |upper[UB_W-1:OFF_W];
        bad_beyond = upper[OFF_W-1:0] > desc.obj_size;

        if (bad_align)       plan.err = ERR_ALIGN;
        else if (bad_range)  plan.err = ERR_RANGE;
        else if (bad_ovf)    plan.err = ERR_OVF;
        else if (bad_beyond) plan.err = ERR_BEYOND;
        else                 plan.err = ERR_NONE;

        plan.start_addr = eff_addr;
        plan.ext_first  = desc.to_imem ? desc.src_off : '0;
        plan.chunks     = n_chunks;
    end
endmodule

// File: rtl/fwl_timer.sv
module fwl_timer #(
    parameter int LIMIT = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/fwl_seq.sv
module fwl_seq
    import fwl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  err_e             plan_err,
    input  logic [CNT_W-1:0] chunks,
    input  logic             eng_idle,
    input  logic             tmo_expired,
    output logic             wr_en,
    output sel_e             wr_sel,
    output logic [CNT_W-1:0] idx,
    output logic             waiting,
    output logic             busy,
    output logic             done,
    output err_e             err_code
);
    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_BLO, S_BHI, S_MOFF, S_EOFF, S_CMD, S_WAIT, S_DONE
    } state_e;

    state_e state;
    err_e   err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            idx   <= '0;
            err_q <= ERR_NONE;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state <= S_CHECK;
                    idx   <= '0;
                    err_q <= ERR_NONE;
                end
                S_CHECK: begin
                    if (plan_err != ERR_NONE) begin
                        err_q <= plan_err;
                        state <= S_DONE;
                    end else if (chunks == '0) begin
                        state <= S_DONE;
                    end else begin
                        state <= S_BLO;
                    end
                end
                S_BLO:  state <= S_BHI;
                S_BHI:  state <= S_MOFF;
                S_MOFF: state <= S_EOFF;
                S_EOFF: state <= S_CMD;
                S_CMD:  state <= S_WAIT;
                S_WAIT: begin
                    if (eng_idle) begin
                        if (idx == chunks - 1'b1) begin
                            state <= S_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_MOFF;
                        end
                    end else if (tmo_expired) begin
                        err_q <= ERR_TIMEOUT;
                        state <= S_DONE;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en  = 1'b1;
        wr_sel = SEL_BASE_LO;
        case (state)
            S_BLO:   wr_sel = SEL_BASE_LO;
            S_BHI:   wr_sel = SEL_BASE_HI;
            S_MOFF:  wr_sel = SEL_MEM_OFF;
            S_EOFF:  wr_sel = SEL_EXT_OFF;
            S_CMD:   wr_sel = SEL_CMD;
            default: wr_en  = 1'b0;
        endcase
    end

    assign waiting  = (state == S_WAIT);
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign err_code = err_q;
endmodule

// File: rtl/fw_chunk_loader.sv
module fw_chunk_loader
    import fwl_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 250_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [63:0]       desc_base,
    input  logic [31:0]       desc_src_off,
    input  logic [31:0]       desc_dst_off,
    input  logic [31:0]       desc_len,
    input  logic [31:0]       desc_obj_size,
    input  logic              desc_to_imem,
    input  logic              desc_secure,
    input  logic              eng_idle,
    output logic              wr_en,
    output logic [2:0]        wr_sel,
    output logic [31:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code
);
    desc_t            desc_q;
    plan_t            plan;
    logic [CNT_W-1:0] idx;
    logic             waiting, tmo_expired;
    sel_e             sel;
    err_e             err;
    logic [OFF_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
        end else if (start && !busy) begin
            desc_q.base     <= desc_base;
            desc_q.src_off  <= desc_src_off;
            desc_q.dst_off  <= desc_dst_off;
            desc_q.len      <= desc_len;
            desc_q.obj_size <= desc_obj_size;
            desc_q.to_imem  <= desc_to_imem;
            desc_q.secure   <= desc_secure;
        end
    end

    fwl_validate u_validate (
        .desc (desc_q),
        .plan (plan)
    );

    fwl_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting && !eng_idle),
        .expired (tmo_expired)
    );

    fwl_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .plan_err    (plan.err),
        .chunks      (plan.chunks),
        .eng_idle    (eng_idle),
        .tmo_expired (tmo_expired),
        .wr_en       (wr_en),
        .wr_sel      (sel),
        .idx         (idx),
        .waiting     (waiting),
        .busy        (busy),
        .done        (done),
        .err_code    (err)
    );

    assign step = OFF_W'(idx) << CHUNK_SH;

    always_comb begin
        case (sel)
            SEL_BASE_LO: wr_data = plan.start_addr[CHUNK_SH +: DATA_W];
            SEL_BASE_HI: wr_data = DATA_W'(plan.start_addr[HI_SHIFT +: HI_W]);
            SEL_MEM_OFF: wr_data = desc_q.dst_off + step;
            SEL_EXT_OFF: wr_data = plan.ext_first + step;
            SEL_CMD:     wr_data = make_cmd(desc_q.to_imem, desc_q.secure);
            default:     wr_data = '0;
        endcase
    end

    assign wr_sel   = sel;
    assign err_code = err;
endmodule

// File: rtl/fwl_loader_chk.sv
module fwl_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        eng_idle,
    input logic [2:0]  err_code
);
    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7
    base_order_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd0) |=> (wr_en && wr_sel == 3'd1));

    // R9
    cmd_size_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd4) |-> (wr_data[6:4] == 3'h6 && wr_data[31:7] == '0));

    // R10
    cmd_pause_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd4) |=> !wr_en);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && $stable(err_code)));

    // R13
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (busy && !done));
endmodule

bind fw_chunk_loader fwl_loader_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .eng_idle (eng_idle),
    .err_code (err_code)
);

// File: tb/fw_chunk_loader_bench.sv
module fw_chunk_loader_bench;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] desc_base = '0;
    logic [31:0] desc_src_off = '0, desc_dst_off = '0, desc_len = '0, desc_obj_size = '0;
    logic        desc_to_imem = 1'b0, desc_secure = 1'b0;
    logic        eng_idle;
    logic        wr_en, busy, done;
    logic [2:0]  wr_sel, err_code;
    logic [31:0] wr_data;

    int n_checks = 0;
    int n_errs   = 0;
    logic hang = 1'b0;
    int eng_cnt = 0;
    int busy_viol = 0;
    int log_n = 0;
    logic [2:0]  log_sel  [256];
    logic [31:0] log_data [256];
    int exp_n = 0;
    logic [2:0]  exp_sel  [256];
    logic [31:0] exp_data [256];

    always #4 clk = ~clk;

    fw_chunk_loader #(.TIMEOUT_CYCLES(TMO)) u_fw_chunk_loader (
        .clk(clk), .rst(rst), .start(start), .desc_base(desc_base),
        .desc_src_off(desc_src_off), .desc_dst_off(desc_dst_off), .desc_len(desc_len),
        .desc_obj_size(desc_obj_size), .desc_to_imem(desc_to_imem), .desc_secure(desc_secure),
        .eng_idle(eng_idle), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .done(done), .err_code(err_code)
    );

    assign eng_idle = (eng_cnt == 0) && !hang;

    always @(posedge clk) begin
        if (rst) begin
            eng_cnt <= 0;
        end else begin
            if (wr_en) begin
                if (log_n < 256) begin
                    log_sel[log_n]  = wr_sel;
                    log_data[log_n] = wr_data;
                end
                log_n = log_n + 1;
                if (eng_cnt != 0) busy_viol = busy_viol + 1;
            end
            if (wr_en && wr_sel == 3'd4) eng_cnt <= 3;
            else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic gen_expected(logic [63:0] base, logic [31:0] src, logic [31:0] dst,
                                logic [31:0] len, logic imem, logic sec);
        logic [64:0] ds;
        int nch;
        ds = {1'b0, base} + (imem ? 65'd0 : {33'd0, src});
        nch = int'((len + 32'd255) >> 8);
        exp_sel[0] = 3'd0; exp_data[0] = ds[39:8];
        exp_sel[1] = 3'd1; exp_data[1] = {16'd0, ds[55:40]};
        exp_n = 2;
        for (int i = 0; i < nch; i++) begin
            exp_sel[exp_n] = 3'd2; exp_data[exp_n] = dst + 32'(i * 256); exp_n++;
            exp_sel[exp_n] = 3'd3; exp_data[exp_n] = (imem ? src : 32'd0) + 32'(i * 256); exp_n++;
            exp_sel[exp_n] = 3'd4;
            exp_data[exp_n] = {25'd0, 3'h6, 2'b00, sec, imem};
            exp_n++;
        end
    endtask

    task automatic run_desc(logic [63:0] base, logic [31:0] src, logic [31:0] dst,
                            logic [31:0] len, logic [31:0] obj, logic imem, logic sec,
                            logic poke, output int cyc, output int mark);
        @(negedge clk);
        desc_base = base; desc_src_off = src; desc_dst_off = dst; desc_len = len;
        desc_obj_size = obj; desc_to_imem = imem; desc_secure = sec;
        mark = log_n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            if (poke && cyc == 6) begin
                start = 1'b1;
                desc_base = 64'h4000; desc_len = 32'h100; desc_to_imem = 1'b0;
                desc_src_off = 32'h0; desc_dst_off = 32'h7700;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= 5000) begin
            n_errs++;
            $display("FAIL R13 done never seen");
        end
    endtask

    task automatic check_log(string req, int mark);
        chk(req, "write count", 64'(log_n - mark), 64'(exp_n));
        for (int i = 0; i < exp_n && (mark + i) < log_n && (mark + i) < 256; i++) begin
            chk(req, "write select", 64'(log_sel[mark + i]), 64'(exp_sel[i]));
            chk(req, "write data", 64'(log_data[mark + i]), 64'(exp_data[i]));
        end
    endtask

    task automatic after_done(string req, logic [2:0] code);
        chk(req, "result code", 64'(err_code), 64'(code));
        @(negedge clk);
        chk("R13", "done drops", 64'(done), 64'd0);
        chk("R13", "code held", 64'(err_code), 64'(code));
    endtask

    task automatic expect_reject(string req, logic [63:0] base, logic [31:0] src,
                                 logic [31:0] len, logic [31:0] obj, logic imem, logic [2:0] code);
        int cyc, mark;
        run_desc(base, src, 32'h0, len, obj, imem, 1'b0, 1'b0, cyc, mark);
        chk(req, "done latency", 64'(cyc), 64'd2);
        chk(req, "no writes", 64'(log_n - mark), 64'd0);
        after_done(req, code);
    endtask

    task automatic t_reset();
        chk("R13", "reset busy", 64'(busy), 64'd0);
        chk("R13", "reset done", 64'(done), 64'd0);
        chk("R13", "reset wr_en", 64'(wr_en), 64'd0);
        chk("R13", "reset code", 64'(err_code), 64'd0);
    endtask

    task automatic t_imem_ok();
        int cyc, mark;
        run_desc(64'h0001_2345_6789_AB00, 32'h300, 32'h100, 32'h250, 32'h1000,
                 1'b1, 1'b1, 1'b0, cyc, mark);
        gen_expected(64'h0001_2345_6789_AB00, 32'h300, 32'h100, 32'h250, 1'b1, 1'b1);
        check_log("R8", mark);
        chk("R9", "three commands", 64'(exp_n), 64'd11);
        after_done("R7", 3'd0);
    endtask

    task automatic t_dmem_ok();
        int cyc, mark;
        run_desc(64'h0000_00A0_8000_0000, 32'h200, 32'h40, 32'h100, 32'h400,
                 1'b0, 1'b0, 1'b0, cyc, mark);
        gen_expected(64'h0000_00A0_8000_0000, 32'h200, 32'h40, 32'h100, 1'b0, 1'b0);
        check_log("R8", mark);
        after_done("R7", 3'd0);
    endtask

    task automatic t_beyond_edge_ok();
        int cyc, mark;
        run_desc(64'h1_0000, 32'h100, 32'h0, 32'h101, 32'h300, 1'b1, 1'b0, 1'b0, cyc, mark);
        gen_expected(64'h1_0000, 32'h100, 32'h0, 32'h101, 1'b1, 1'b0);
        check_log("R5", mark);
        after_done("R5", 3'd0);
    endtask

    task automatic t_zero();
        int cyc, mark;
        run_desc(64'h2000, 32'h0, 32'h0, 32'h0, 32'h10, 1'b1, 1'b0, 1'b0, cyc, mark);
        chk("R12", "done latency", 64'(cyc), 64'd2);
        chk("R12", "no writes", 64'(log_n - mark), 64'd0);
        after_done("R12", 3'd0);
    endtask

    task automatic t_timeout();
        int cyc, mark;
        hang = 1'b1;
        run_desc(64'h3000, 32'h0, 32'h0, 32'h200, 32'h1000, 1'b1, 1'b0, 1'b0, cyc, mark);
        gen_expected(64'h3000, 32'h0, 32'h0, 32'h200, 1'b1, 1'b0);
        exp_n = 5;
        check_log("R11", mark);
        after_done("R11", 3'd5);
        hang = 1'b0;
    endtask

    task automatic t_busy_ignore();
        int cyc, mark;
        run_desc(64'h5_0000, 32'h0, 32'h800, 32'h300, 32'h300, 1'b1, 1'b1, 1'b1, cyc, mark);
        gen_expected(64'h5_0000, 32'h0, 32'h800, 32'h300, 1'b1, 1'b1);
        check_log("R1", mark);
        after_done("R1", 3'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_imem_ok();
        t_dmem_ok();
        t_beyond_edge_ok();
        expect_reject("R2", 64'h1000, 32'h10, 32'h100, 32'h1000, 1'b0, 3'd1);
        expect_reject("R2", 64'h1040, 32'h0, 32'h100, 32'h1000, 1'b1, 3'd1);
        expect_reject("R3", 64'h0002_0000_0000_0000, 32'h0, 32'h100, 32'h1000, 1'b1, 3'd2);
        expect_reject("R4", 64'h1000, 32'h0, 32'hFFFF_FF01, 32'hFFFF_FFFF, 1'b1, 3'd3);
        expect_reject("R5", 64'h1000, 32'h101, 32'h100, 32'h200, 1'b1, 3'd4);
        expect_reject("R6", 64'h0004_0000_0000_0004, 32'h0, 32'hFFFF_FF01, 32'h0, 1'b1, 3'd1);
        expect_reject("R6", 64'h0004_0000_0000_0000, 32'h0, 32'hFFFF_FF01, 32'h0, 1'b1, 3'd2);
        expect_reject("R6", 64'h1000, 32'h10, 32'hFFFF_FF01, 32'h0, 1'b1, 3'd3);
        t_zero();
        t_busy_ignore();
        t_timeout();
        chk("R10", "writes while engine busy", 64'(busy_viol), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule